// File: doc/BRIEF.md
# Link Status Config Word Handshake

This block moves port status from the PHY end of a serial link to the MAC end as a 16-bit control word, and sends an acknowledge back. On the PHY side an advertiser packs link state, duplex and speed into the word. It transmits that word on every cycle until the partner has acknowledged and a link timer has run out. On the MAC side a receiver accepts a word only after it has seen the same value several times in a row. It then reports the decoded status and answers each incoming word with a reply word that carries the acknowledge bit.

Both ends are instantiated inside the top module and wired back to back. Each direction is exposed as a 16-bit word with a valid strobe, so the exchange can be observed at the ports. Any change of link, duplex or speed at the PHY inputs starts a new exchange, including a change that arrives while an exchange is still running. The link timer length and the required run of identical words are parameters. The timer defaults to 200000 cycles, which is 1.6 ms at 125 MHz.

Top module: `cfgx_status_exchange`

## Requirements
- R1: While reset is held, `phy_done`, `phy_word_vld`, `mac_word_vld` and `mac_status_vld` are 0.
- R2: Every word sent by the PHY has bit 15 = link (1 = up), bit 12 = duplex (1 = full), bits 11:10 = speed (2'b10 = 1000, 2'b01 = 100, 2'b00 = 10) and bit 0 = 1. All other bits, including bit 14, are 0.
- R3: The MAC takes a word only after MATCH_CNT consecutive valid words agree in every bit except bit 14. It then drives `mac_link_up`, `mac_full_dpx` and `mac_speed` from bits 15, 12 and 11:10 of that word and sets `mac_status_vld`.
- R4: The MAC sends one reply word, one cycle after each valid incoming word. The reply is 16'h4001 (bit 14 acknowledge, bit 0 set) once the incoming word has been taken, and 16'h0001 otherwise.
- R5: An exchange starts after reset and whenever link, duplex or effective speed changes. One cycle after the change is registered, the PHY sends its word on every cycle until it is done.
- R6: The PHY reports `phy_done` only after MATCH_CNT consecutive acknowledge replies, followed by LINK_TIMER_CYC cycles with no reply that lacks the acknowledge. An exchange that is not disturbed lasts between LINK_TIMER_CYC and LINK_TIMER_CYC+12 cycles from the change.
- R7: While `phy_done` is 1, no PHY word is sent, and the MAC status outputs hold their values.
- R8: A speed input of 2'b11 is reserved and is never advertised. The PHY keeps the last valid speed. If nothing else changed, no exchange starts.
- R9: A status change during an exchange restarts the exchange with the new word. A change in the same cycle that the link timer expires takes precedence, so `phy_done` stays 0. The MAC ends up with the newest status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_link_up | input | 1 | PHY link state to advertise |
| phy_full_dpx | input | 1 | PHY duplex to advertise (1 = full) |
| phy_speed | input | 2 | PHY speed code to advertise |
| phy_word | output | 16 | Config word from PHY to MAC |
| phy_word_vld | output | 1 | Strobe for `phy_word` |
| phy_done | output | 1 | PHY exchange complete |
| mac_word | output | 16 | Reply word from MAC to PHY |
| mac_word_vld | output | 1 | Strobe for `mac_word` |
| mac_link_up | output | 1 | Link state taken by the MAC |
| mac_full_dpx | output | 1 | Duplex taken by the MAC |
| mac_speed | output | 2 | Speed code taken by the MAC |
| mac_status_vld | output | 1 | MAC has taken at least one word |

## Verification
Two things can happen in the same cycle: the link timer can expire and move the advertiser to done, while a new status change can demand a restart. The bench first times an undisturbed exchange from change to `phy_done`. It then applies a second change so that it is registered on exactly the edge where the timer would expire. `phy_done` is checked to stay low at that point, and the MAC is checked to end up with the second status after the restarted exchange completes.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int CFG_W       = 16;
   localparam int LINK_BIT    = 15;
   localparam int ACK_BIT     = 14;
   localparam int DPX_BIT     = 12;
   localparam int SPD_HI      = 11;
   localparam int SPD_LO      = 10;
   localparam int MARK_BIT    = 0;

   localparam logic [1:0]       SPD_RSVD  = 2'b11;
   localparam logic [1:0]       SPD_1000  = 2'b10;
   localparam logic [CFG_W-1:0] ACK_WORD  = 16'h4001;
   localparam logic [CFG_W-1:0] NACK_WORD = 16'h0001;
   localparam logic [CFG_W-1:0] CMP_MASK  = ~(16'h0001 << ACK_BIT);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_ACK_WAIT,
      ST_TIMER,
      ST_DONE
   } adv_state_e;

   typedef struct packed {
      logic       link;
      logic       full_dpx;
      logic [1:0] speed;
   } link_stat_t;

   function automatic logic [CFG_W-1:0] pack_word(input link_stat_t s);
      logic [CFG_W-1:0] w;
      w                = '0;
      w[MARK_BIT]      = 1'b1;
      w[LINK_BIT]      = s.link;
      w[DPX_BIT]       = s.full_dpx;
      w[SPD_HI:SPD_LO] = s.speed;
      return w;
   endfunction

endpackage

// File: rtl/cfgx_run_count.sv
module cfgx_run_count #(
   parameter int N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld,
   input  logic same,
   output logic full_now
);
   localparam int CW = $clog2(N + 1);

   logic [CW-1:0] cnt, nxt;

   always_comb begin
      if (!vld)               nxt = '0;
      else if (!same)         nxt = CW'(1);
      else if (cnt == CW'(N)) nxt = cnt;
      else                    nxt = cnt + CW'(1);
   end

   assign full_now = vld && (nxt == CW'(N));

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/cfgx_link_timer.sv
module cfgx_link_timer #(
   parameter int CYC = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(CYC);

   logic [TW-1:0] cnt;

   assign expired = run && (cnt == TW'(CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (!expired)  cnt <= cnt + TW'(1);
   end
endmodule

// File: rtl/cfgx_phy_adv.sv
module cfgx_phy_adv
   import cfgx_pkg::*;
#(
   parameter int MATCH_CNT      = 3,
   parameter int LINK_TIMER_CYC = 200000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  link_stat_t       stat_in,
   input  logic             rx_vld,
   input  logic             rx_ack,
   output logic [CFG_W-1:0] tx_word,
   output logic             tx_vld,
   output logic             done
);
   adv_state_e state, state_nxt;
   link_stat_t adv, want;
   logic       chg, ack_full, tmr_exp;

   // reserved speed code never reaches the word
   always_comb begin
      want = stat_in;
      if (stat_in.speed == SPD_RSVD) want.speed = adv.speed;
   end
   assign chg = (want != adv);

   cfgx_run_count #(.N(MATCH_CNT)) ack_run_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (rx_vld && rx_ack && (state == ST_ACK_WAIT)),
      .same     (1'b1),
      .full_now (ack_full)
   );

   cfgx_link_timer #(.CYC(LINK_TIMER_CYC)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_TIMER),
      .expired (tmr_exp)
   );

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:     state_nxt = ST_SEND;
         ST_SEND:     state_nxt = ST_ACK_WAIT;
         ST_ACK_WAIT: if (ack_full) state_nxt = ST_TIMER;
         ST_TIMER: begin
            if (rx_vld && !rx_ack) state_nxt = ST_SEND;
            else if (tmr_exp)      state_nxt = ST_DONE;
         end
         ST_DONE:     state_nxt = ST_DONE;
         default:     state_nxt = ST_IDLE;
      endcase
      // a status change beats every other transition, timer expiry included
      if (chg && state != ST_IDLE) state_nxt = ST_SEND;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         adv   <= '{link: 1'b0, full_dpx: 1'b0, speed: SPD_1000};
      end else begin
         state <= state_nxt;
         adv   <= want;
      end
   end

   assign tx_word = pack_word(adv);
   assign tx_vld  = (state == ST_ACK_WAIT) || (state == ST_TIMER);
   assign done    = (state == ST_DONE);
endmodule

// File: rtl/cfgx_mac_ack.sv
module cfgx_mac_ack
   import cfgx_pkg::*;
#(
   parameter int MATCH_CNT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] in_word,
   input  logic             in_vld,
   output logic [CFG_W-1:0] out_word,
   output logic             out_vld,
   output link_stat_t       stat_out,
   output logic             stat_vld
);
   logic [CFG_W-1:0] last;
   logic             same, took, ack_q;

   assign same = (((in_word ^ last) & CMP_MASK) == '0);

   cfgx_run_count #(.N(MATCH_CNT)) word_run_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (in_vld && in_word[MARK_BIT]),
      .same     (same),
      .full_now (took)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last     <= '0;
         out_vld  <= 1'b0;
         ack_q    <= 1'b0;
         stat_out <= '0;
         stat_vld <= 1'b0;
      end else begin
         if (in_vld) last <= in_word;
         out_vld <= in_vld;
         ack_q   <= took;
         if (took) begin
            stat_out <= '{link: in_word[LINK_BIT], full_dpx: in_word[DPX_BIT],
                          speed: in_word[SPD_HI:SPD_LO]};
            stat_vld <= 1'b1;
         end
      end
   end

   assign out_word = ack_q ? ACK_WORD : NACK_WORD;
endmodule

// File: rtl/cfgx_status_exchange.sv
module cfgx_status_exchange
   import cfgx_pkg::*;
#(
   parameter int MATCH_CNT      = 3,
   parameter int LINK_TIMER_CYC = 200000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        phy_link_up,
   input  logic        phy_full_dpx,
   input  logic [1:0]  phy_speed,
   output logic [15:0] phy_word,
   output logic        phy_word_vld,
   output logic        phy_done,
   output logic [15:0] mac_word,
   output logic        mac_word_vld,
   output logic        mac_link_up,
   output logic        mac_full_dpx,
   output logic [1:0]  mac_speed,
   output logic        mac_status_vld
);
   if (MATCH_CNT < 1) begin : g_bad_match
      $error("MATCH_CNT must be at least 1");
   end
   if (LINK_TIMER_CYC < 2) begin : g_bad_timer
      $error("LINK_TIMER_CYC must be at least 2");
   end

   link_stat_t phy_st, mac_st;

   assign phy_st = {phy_link_up, phy_full_dpx, phy_speed};

   cfgx_phy_adv #(
      .MATCH_CNT      (MATCH_CNT),
      .LINK_TIMER_CYC (LINK_TIMER_CYC)
   ) phy_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_in (phy_st),
      .rx_vld  (mac_word_vld),
      .rx_ack  (mac_word[ACK_BIT]),
      .tx_word (phy_word),
      .tx_vld  (phy_word_vld),
      .done    (phy_done)
   );

   cfgx_mac_ack #(.MATCH_CNT(MATCH_CNT)) mac_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_word  (phy_word),
      .in_vld   (phy_word_vld),
      .out_word (mac_word),
      .out_vld  (mac_word_vld),
      .stat_out (mac_st),
      .stat_vld (mac_status_vld)
   );

   assign mac_link_up  = mac_st.link;
   assign mac_full_dpx = mac_st.full_dpx;
   assign mac_speed    = mac_st.speed;
endmodule

// File: rtl/cfgx_status_exchange_chk.sv
module cfgx_status_exchange_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        phy_link_up,
   input logic        phy_full_dpx,
   input logic [1:0]  phy_speed,
   input logic [15:0] phy_word,
   input logic        phy_word_vld,
   input logic        phy_done,
   input logic [15:0] mac_word,
   input logic        mac_word_vld,
   input logic        mac_link_up,
   input logic        mac_full_dpx,
   input logic [1:0]  mac_speed,
   input logic        mac_status_vld
);
   logic unused_in;
   assign unused_in = ^{phy_link_up, phy_full_dpx, phy_speed};

   // R2: fixed bits of the PHY word
   a_r2_word_format: assert property (@(posedge clk) disable iff (!rst_n)
      phy_word_vld |-> (phy_word[0] && phy_word[14:13] == 2'b00 && phy_word[9:1] == 9'd0));

   // R8: reserved speed never on the wire
   a_r8_no_reserved_speed: assert property (@(posedge clk) disable iff (!rst_n)
      phy_word_vld |-> (phy_word[11:10] != 2'b11));

   // R4: reply is one of two words
   a_r4_reply_format: assert property (@(posedge clk) disable iff (!rst_n)
      mac_word_vld |-> (mac_word == 16'h4001 || mac_word == 16'h0001));

   // R4: an acknowledge is only sent after a word was taken
   a_r4_ack_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_word_vld && mac_word[14]) |-> mac_status_vld);

   // R7: nothing sent while done
   a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      phy_done |-> !phy_word_vld);

   // R7: MAC status only moves after an incoming word
   a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(phy_word_vld) |-> $stable({mac_link_up, mac_full_dpx, mac_speed, mac_status_vld}));

   // R6: done is entered only with the acknowledge present
   a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_done) |-> $past(mac_word_vld && mac_word[14]));
endmodule

bind cfgx_status_exchange cfgx_status_exchange_chk chk_i (.*);

// File: tb/cfgx_status_exchange_tb.sv
module cfgx_status_exchange_tb_top;
   localparam int MATCH = 3;
   localparam int LINK  = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lnk = 1'b1, dpx = 1'b1;
   logic [1:0]  spd = 2'b10;
   logic [15:0] phy_word, mac_word;
   logic        phy_word_vld, phy_done, mac_word_vld;
   logic        mac_link_up, mac_full_dpx, mac_status_vld;
   logic [1:0]  mac_speed;

   int checks = 0, errors = 0;
   int wcnt = 0, wbad = 0, abad = 0;
   logic       e_link = 1'b1, e_dpx = 1'b1;
   logic [1:0] e_spd = 2'b10;

   always #10 clk = ~clk;

   cfgx_status_exchange #(.MATCH_CNT(MATCH), .LINK_TIMER_CYC(LINK)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .phy_link_up(lnk), .phy_full_dpx(dpx), .phy_speed(spd),
      .phy_word(phy_word), .phy_word_vld(phy_word_vld), .phy_done(phy_done),
      .mac_word(mac_word), .mac_word_vld(mac_word_vld),
      .mac_link_up(mac_link_up), .mac_full_dpx(mac_full_dpx),
      .mac_speed(mac_speed), .mac_status_vld(mac_status_vld)
   );

   function automatic logic [15:0] exp_word(logic l, logic d, logic [1:0] s);
      return {l, 1'b0, 1'b0, d, s, 9'd0, 1'b1};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor samples at negedge; drives happen 1 ns later
   always @(negedge clk) begin
      if (rst_n && phy_word_vld) begin
         wcnt++;
         if (phy_word !== exp_word(e_link, e_dpx, e_spd)) wbad++;
      end
      if (rst_n && mac_word_vld && mac_word !== 16'h4001 && mac_word !== 16'h0001) abad++;
   end

   task automatic apply(input logic l, input logic d, input logic [1:0] s);
      @(negedge clk); #1;
      lnk = l; dpx = d; spd = s;
      e_link = l; e_dpx = d;
      if (s != 2'b11) e_spd = s;
      wcnt = 0; wbad = 0; abad = 0;
   endtask

   task automatic wait_done(output int k);
      k = 0;
      do begin @(negedge clk); k++; end while (!phy_done && k < 2000);
   endtask

   task automatic check_status(input string req);
      chk(mac_status_vld == 1'b1, req, "status valid", int'(mac_status_vld), 1);
      chk(mac_link_up == e_link, req, "link", int'(mac_link_up), int'(e_link));
      chk(mac_full_dpx == e_dpx, req, "duplex", int'(mac_full_dpx), int'(e_dpx));
      chk(mac_speed == e_spd, req, "speed", int'(mac_speed), int'(e_spd));
   endtask

   task automatic check_exchange(input int k);
      check_status("R3");
      chk(wbad == 0, "R2", "word mismatches", wbad, 0);
      chk(abad == 0, "R4", "bad reply words", abad, 0);
      chk(k >= LINK && k <= LINK + 12, "R6", "exchange length", k, LINK);
      chk(wcnt == k - 2, "R5", "words sent", wcnt, k - 2);
   endtask

   initial begin
      int k, t_clean, r;
      logic l, d;
      logic [1:0] s;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(!phy_done && !phy_word_vld && !mac_word_vld && !mac_status_vld, "R1",
          "outputs in reset", int'({phy_done, phy_word_vld, mac_word_vld, mac_status_vld}), 0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      wcnt = 0; wbad = 0; abad = 0;
      // R5: exchange after reset
      wait_done(k);
      check_status("R5");
      chk(wbad == 0, "R2", "word mismatches after reset", wbad, 0);

      // directed clean exchange, timed for the collision case
      apply(1'b1, 1'b0, 2'b01);
      wait_done(t_clean);
      check_exchange(t_clean);

      // R7: quiet while done, status held
      begin
         int seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (phy_word_vld || !phy_done) seen++;
         end
         chk(seen == 0, "R7", "activity while done", seen, 0);
         check_status("R7");
      end

      // R8: reserved speed alone starts nothing
      apply(e_link, e_dpx, 2'b11);
      begin
         int seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (phy_word_vld || !phy_done) seen++;
         end
         chk(seen == 0, "R8", "exchange on reserved speed", seen, 0);
         chk(mac_speed == 2'b01, "R8", "speed kept", int'(mac_speed), 1);
      end
      // R8: reserved speed with a link change keeps the old speed
      apply(1'b0, e_dpx, 2'b11);
      wait_done(k);
      check_exchange(k);
      chk(mac_speed == 2'b01, "R8", "speed after link change", int'(mac_speed), 1);

      // R9: change while waiting for acknowledge
      apply(1'b1, 1'b1, 2'b00);
      repeat (4) @(negedge clk); #1;
      lnk = 1'b1; dpx = 1'b0; spd = 2'b10;
      e_link = 1'b1; e_dpx = 1'b0; e_spd = 2'b10;
      wcnt = 0; wbad = 0;
      wait_done(k);
      check_status("R9");
      chk(wbad == 0, "R9", "word after restart", wbad, 0);

      // R9: change on the timer expiry edge
      apply(1'b0, 1'b1, 2'b01);
      for (int i = 0; i < t_clean - 1; i++) @(negedge clk);
      #1;
      lnk = 1'b1; dpx = 1'b1; spd = 2'b00;
      e_link = 1'b1; e_dpx = 1'b1; e_spd = 2'b00;
      wcnt = 0; wbad = 0;
      @(negedge clk);
      chk(phy_done == 1'b0, "R9", "done on collision edge", int'(phy_done), 0);
      wait_done(k);
      check_status("R9");
      chk(wbad == 0, "R9", "word after collision", wbad, 0);

      // random exchanges
      for (int n = 0; n < 10; n++) begin
         r = $urandom;
         l = r[0]; d = r[1]; s = 2'(r[7:2] % 3);
         if (l == e_link && d == e_dpx && s == e_spd) l = ~e_link;
         apply(l, d, s);
         wait_done(k);
         check_exchange(k);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule